// File: doc/BRIEF.md
# Active Priority Tracker with End-of-Interrupt Handling

This block sits in the CPU-facing side of an interrupt controller. It keeps one active-priority bitmap for each of three interrupt groups: group 0, secure group 1 and non-secure group 1. Each bitmap holds one bit per preemption level, and the bits are grouped into 32-bit words. When the core acknowledges an interrupt, the block sets the bit for that interrupt's masked priority in the bitmap of its group. When the core writes an end-of-interrupt, the block checks the ID and the group. If the write is accepted, the block performs a priority drop, and it can also issue a deactivate request for the ID.

The block continuously reports which group holds the most urgent active interrupt. It also reports the running priority, both as a plain value and as a reduced view for non-secure readers. The pending and active state of each interrupt is stored outside this block and is updated from the deactivate request.

Top module: `active_prio_tracker`

## Requirements
- R1: After reset, all three bitmaps are zero, `runPrio` is 0xFF and `deactValid` is low.
- R2: An acknowledge with group code 0 (group 0), 1 (secure group 1) or 2 (non-secure group 1) sets bitmap bit `idx = (ackPrio & ackMask) >> 1` of that group. This is bit `idx % 32` of word `idx / 32`, which is `activeMap[g*128 + idx]`. Group code 3 is ignored.
- R3: A priority drop for a group clears only the lowest set bit of that group's bitmap. All other bits are left unchanged.
- R4: The winning group is the group that holds the lowest set bit index over all three bitmaps. On a tie, group 0 wins over secure group 1, and secure group 1 wins over non-secure group 1. If all bitmaps are empty there is no winner, and every end-of-interrupt is ignored.
- R5: An end-of-interrupt with an ID (24 bits) that is at or above `numIds` has no effect. This covers the special IDs 1020 to 1023 whenever `numIds` is 1020.
- R6: An end-of-interrupt whose group code differs from the current winning group has no effect.
- R7: An accepted end-of-interrupt with `eoiSplit` low drops priority and raises `deactValid` for exactly one cycle after the edge, with `deactId` set to the ID. With `eoiSplit` high it only drops priority.
- R8: `runPrio` equals twice the lowest set bit index across all bitmaps, or 0xFF when all bitmaps are empty. It reflects the state after the clock edge that accepted the event.
- R9: With `nsReader` high, `readPrio` is 0 when `runPrio` bit 7 is set (this includes idle 0xFF). Otherwise it is `runPrio` shifted left by one and truncated to 8 bits. With `nsReader` low, `readPrio` equals `runPrio`.
- R10: When an acknowledge and an end-of-interrupt occur in the same cycle, the acknowledge is applied first. The winner check and the drop therefore see the newly set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ackValid | input | 1 | Acknowledge event |
| ackGroup | input | 2 | Group code of the acknowledged interrupt |
| ackPrio | input | 8 | Priority of the acknowledged interrupt |
| ackMask | input | 8 | Binary-point mask for that group |
| eoiValid | input | 1 | End-of-interrupt write |
| eoiId | input | 24 | Interrupt ID carried by the write |
| eoiGroup | input | 2 | Group code the write targets |
| eoiSplit | input | 1 | Split mode: drop priority only |
| numIds | input | 25 | Number of implemented interrupt IDs |
| nsReader | input | 1 | Selects the non-secure view on `readPrio` |
| deactValid | output | 1 | Deactivate request |
| deactId | output | 24 | ID to deactivate |
| runPrio | output | 8 | Running priority |
| readPrio | output | 8 | Running priority as seen by the reader |
| activeMap | output | 384 | Bitmaps, group g at bits g*128 upward |

## Verification
The bench uses the default parameters: an 8-bit priority, which gives 128-bit bitmaps of four 32-bit words. This makes word-boundary indices such as 24, 32 and 127 reachable, and it exposes the per-word scan against a single global ordering in the reference model. Because `numIds` is driven at run time, the same build covers both small ID limits and the 1020 limit that filters out the special IDs.

// File: rtl/apt_pkg.sv
package apt_pkg;
  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_NONE = 2'd3
  } grpE;

  typedef struct packed {
    logic ackSet;
    grpE  ackGrp;
    logic dropEn;
    grpE  dropGrp;
  } aptStrobeS;
endpackage

// File: rtl/apt_group_pick.sv
module apt_group_pick
  import apt_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4
) (
  input  logic [NUM_WORDS*WORD_W-1:0] mapG0,
  input  logic [NUM_WORDS*WORD_W-1:0] mapG1s,
  input  logic [NUM_WORDS*WORD_W-1:0] mapG1ns,
  output logic                        found,
  output grpE                         winGrp
);
  localparam int CW = $clog2(WORD_W) + 1;

  function automatic logic [CW-1:0] ctzWord(input logic [WORD_W-1:0] v);
    ctzWord = CW'(WORD_W);
    for (int b = WORD_W - 1; b >= 0; b--) begin
      if (v[b]) ctzWord = CW'(b);
    end
  endfunction

  logic [CW-1:0] c0, c1, cN;

  always_comb begin
    found  = 1'b0;
    winGrp = GRP_NONE;
    c0 = '0;
    c1 = '0;
    cN = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (!found) begin
        c0 = ctzWord(mapG0[w*WORD_W +: WORD_W]);
        c1 = ctzWord(mapG1s[w*WORD_W +: WORD_W]);
        cN = ctzWord(mapG1ns[w*WORD_W +: WORD_W]);
        if (cN < c0 && cN < c1) begin
          found  = 1'b1;
          winGrp = GRP_G1NS;
        end else if (c1 < c0) begin
          found  = 1'b1;
          winGrp = GRP_G1S;
        end else if (c0 < CW'(WORD_W)) begin
          found  = 1'b1;
          winGrp = GRP_G0;
        end
      end
    end
  end
endmodule

// File: rtl/apt_ctrl.sv
module apt_ctrl
  import apt_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int ID_W      = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ackValid,
  input  logic [1:0]                    ackGroup,
  input  logic                          eoiValid,
  input  logic [ID_W-1:0]               eoiId,
  input  logic [1:0]                    eoiGroup,
  input  logic                          eoiSplit,
  input  logic [ID_W:0]                 numIds,
  input  logic [3*NUM_WORDS*WORD_W-1:0] mapAck,
  output aptStrobeS                     strb,
  output logic                          deactValid,
  output logic [ID_W-1:0]               deactId
);
  localparam int MAP_BITS = NUM_WORDS * WORD_W;

  logic idOk;
  logic found;
  grpE  winGrp;
  logic accept;

  apt_group_pick #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) uPick (
    .mapG0  (mapAck[0*MAP_BITS +: MAP_BITS]),
    .mapG1s (mapAck[1*MAP_BITS +: MAP_BITS]),
    .mapG1ns(mapAck[2*MAP_BITS +: MAP_BITS]),
    .found  (found),
    .winGrp (winGrp)
  );

  assign idOk   = {1'b0, eoiId} < numIds;
  assign accept = eoiValid && idOk && found && (grpE'(eoiGroup) == winGrp);

  always_comb begin
    strb.ackSet  = ackValid && (ackGroup != 2'd3);
    strb.ackGrp  = grpE'(ackGroup);
    strb.dropEn  = accept;
    strb.dropGrp = winGrp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deactValid <= 1'b0;
      deactId    <= '0;
    end else begin
      deactValid <= accept && !eoiSplit;
      deactId    <= (accept && !eoiSplit) ? eoiId : '0;
    end
  end

  // R7: a deactivate request only follows an unsplit end-of-interrupt
  assert_deact_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    deactValid |-> $past(eoiValid && !eoiSplit && idOk));
  // R7: the request carries the ID of that write
  assert_deact_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
    deactValid |-> deactId == $past(eoiId));
endmodule

// File: rtl/apt_data.sv
module apt_data
  import apt_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int WORD_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  aptStrobeS                      strb,
  input  logic [PRIO_W-1:0]              ackPrio,
  input  logic [PRIO_W-1:0]              ackMask,
  input  logic                           nsReader,
  output logic [3*(2**(PRIO_W-1))-1:0]   mapAck,
  output logic [3*(2**(PRIO_W-1))-1:0]   mapQ,
  output logic [PRIO_W-1:0]              runPrio,
  output logic [PRIO_W-1:0]              readPrio
);
  localparam int MAP_BITS  = 2 ** (PRIO_W - 1);
  localparam int NUM_WORDS = MAP_BITS / WORD_W;
  localparam int IDX_W     = PRIO_W - 1;

  logic [PRIO_W-1:0]     maskedPrio;
  logic [IDX_W-1:0]      ackIdx;
  logic [3*MAP_BITS-1:0] mapNext;
  logic [MAP_BITS-1:0]   allOr;
  logic [IDX_W-1:0]      lowIdx;
  logic                  anyActive;

  assign maskedPrio = ackPrio & ackMask;
  assign ackIdx     = maskedPrio[PRIO_W-1:1];

  always_comb begin
    mapAck = mapQ;
    if (strb.ackSet) mapAck[int'(strb.ackGrp)*MAP_BITS + int'(ackIdx)] = 1'b1;
  end

  always_comb begin
    logic done;
    logic [WORD_W-1:0] w;
    mapNext = mapAck;
    done = 1'b0;
    w = '0;
    if (strb.dropEn) begin
      for (int k = 0; k < NUM_WORDS; k++) begin
        w = mapAck[int'(strb.dropGrp)*MAP_BITS + k*WORD_W +: WORD_W];
        if (!done && w != '0) begin
          mapNext[int'(strb.dropGrp)*MAP_BITS + k*WORD_W +: WORD_W] = w & (w - 1'b1);
          done = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mapQ <= '0;
    else        mapQ <= mapNext;
  end

  assign allOr = mapQ[0 +: MAP_BITS] | mapQ[MAP_BITS +: MAP_BITS] | mapQ[2*MAP_BITS +: MAP_BITS];

  always_comb begin
    lowIdx    = '0;
    anyActive = 1'b0;
    for (int i = MAP_BITS - 1; i >= 0; i--) begin
      if (allOr[i]) begin
        lowIdx    = IDX_W'(i);
        anyActive = 1'b1;
      end
    end
  end

  assign runPrio  = anyActive ? {lowIdx, 1'b0} : '1;
  assign readPrio = !nsReader ? runPrio :
                    (runPrio[PRIO_W-1] ? '0 : (runPrio << 1));

  // R5: with neither a set nor a drop, the bitmaps hold
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.ackSet && !strb.dropEn) |=> $stable(mapQ));
  // R3: a lone drop removes exactly one active bit
  assert_drop_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.dropEn && !strb.ackSet) |=> $countones(mapQ) == $past($countones(mapQ)) - 1);
  // R8: empty bitmaps read as idle
  assert_idle_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mapQ == '0) |-> runPrio == '1);
  // R9: the secure half of the range is hidden from non-secure readers
  assert_ns_hide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nsReader && runPrio[PRIO_W-1]) |-> readPrio == '0);
endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker
  import apt_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int WORD_W = 32,
  parameter int ID_W   = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ackValid,
  input  logic [1:0]                   ackGroup,
  input  logic [PRIO_W-1:0]            ackPrio,
  input  logic [PRIO_W-1:0]            ackMask,
  input  logic                         eoiValid,
  input  logic [ID_W-1:0]              eoiId,
  input  logic [1:0]                   eoiGroup,
  input  logic                         eoiSplit,
  input  logic [ID_W:0]                numIds,
  input  logic                         nsReader,
  output logic                         deactValid,
  output logic [ID_W-1:0]              deactId,
  output logic [PRIO_W-1:0]            runPrio,
  output logic [PRIO_W-1:0]            readPrio,
  output logic [3*(2**(PRIO_W-1))-1:0] activeMap
);
  localparam int MAP_BITS  = 2 ** (PRIO_W - 1);
  localparam int NUM_WORDS = MAP_BITS / WORD_W;

  aptStrobeS             strb;
  logic [3*MAP_BITS-1:0] mapAck;

  apt_ctrl #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ID_W(ID_W)) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .ackValid(ackValid), .ackGroup(ackGroup),
    .eoiValid(eoiValid), .eoiId(eoiId), .eoiGroup(eoiGroup), .eoiSplit(eoiSplit),
    .numIds(numIds), .mapAck(mapAck), .strb(strb),
    .deactValid(deactValid), .deactId(deactId)
  );

  apt_data #(.PRIO_W(PRIO_W), .WORD_W(WORD_W)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .ackPrio(ackPrio), .ackMask(ackMask), .nsReader(nsReader),
    .mapAck(mapAck), .mapQ(activeMap), .runPrio(runPrio), .readPrio(readPrio)
  );
endmodule

// File: tb/sim_active_prio_tracker.sv
module sim_active_prio_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int MAPB = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ackValid = 0;
  logic [1:0] ackGroup = 0;
  logic [7:0] ackPrio = 0, ackMask = 0;
  logic eoiValid = 0;
  logic [23:0] eoiId = 0;
  logic [1:0] eoiGroup = 0;
  logic eoiSplit = 0;
  logic [24:0] numIds = 0;
  logic nsReader = 0;
  logic deactValid;
  logic [23:0] deactId;
  logic [7:0] runPrio, readPrio;
  logic [3*MAPB-1:0] activeMap;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [MAPB-1:0] mdl [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  active_prio_tracker u0 (
    .clk(clk), .rst_n(rst_n), .ackValid(ackValid), .ackGroup(ackGroup),
    .ackPrio(ackPrio), .ackMask(ackMask), .eoiValid(eoiValid), .eoiId(eoiId),
    .eoiGroup(eoiGroup), .eoiSplit(eoiSplit), .numIds(numIds), .nsReader(nsReader),
    .deactValid(deactValid), .deactId(deactId), .runPrio(runPrio),
    .readPrio(readPrio), .activeMap(activeMap)
  );

  task automatic chk(input string tag, input logic [MAPB-1:0] act, input logic [MAPB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int winner();
    for (int i = 0; i < MAPB; i++) begin
      if (mdl[0][i]) return 0;
      if (mdl[1][i]) return 1;
      if (mdl[2][i]) return 2;
    end
    return 3;
  endfunction

  function automatic logic [7:0] expRun();
    for (int i = 0; i < MAPB; i++)
      if (mdl[0][i] | mdl[1][i] | mdl[2][i]) return 8'(2 * i);
    return 8'hFF;
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] r, input logic ns);
    if (!ns) return r;
    if (r[7]) return 8'h00;
    return 8'(r << 1);
  endfunction

  task automatic step(input logic av, input logic [1:0] ag, input logic [7:0] ap,
                      input logic [7:0] am, input logic ev, input logic [23:0] id,
                      input logic [1:0] eg, input logic sp, input logic [24:0] nid,
                      input logic ns, input string tag);
    logic expDv;
    logic [23:0] expId;
    int w;
    @(negedge clk);
    ackValid = av; ackGroup = ag; ackPrio = ap; ackMask = am;
    eoiValid = ev; eoiId = id; eoiGroup = eg; eoiSplit = sp; numIds = nid; nsReader = ns;
    if (av && ag != 2'd3) mdl[ag][(ap & am) >> 1] = 1'b1;
    expDv = 1'b0; expId = '0;
    if (ev && {1'b0, id} < nid) begin
      w = winner();
      if (w != 3 && w == int'(eg)) begin
        mdl[w] = mdl[w] & (mdl[w] - 1'b1);
        if (!sp) begin expDv = 1'b1; expId = id; end
      end
    end
    @(posedge clk);
    #1;
    for (int g = 0; g < 3; g++) chk({tag, " map"}, activeMap[g*MAPB +: MAPB], mdl[g]);
    chk({tag, " R8 runPrio"}, MAPB'(runPrio), MAPB'(expRun()));
    chk({tag, " R9 readPrio"}, MAPB'(readPrio), MAPB'(expRead(expRun(), ns)));
    chk({tag, " R7 deactValid"}, MAPB'(deactValid), MAPB'(expDv));
    if (expDv) chk({tag, " R7 deactId"}, MAPB'(deactId), MAPB'(expId));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp=<200000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int r, ag, eg;
    logic [7:0] masks [5];
    masks = '{8'hFF, 8'hFE, 8'hFC, 8'hF8, 8'hF0};
    r = $urandom(32'h5EED);
    for (int g = 0; g < 3; g++) mdl[g] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 map", activeMap[MAPB-1:0] | activeMap[2*MAPB-1:MAPB] | activeMap[3*MAPB-1:2*MAPB], '0);
    chk("R1 runPrio", MAPB'(runPrio), MAPB'(8'hFF));
    chk("R1 deactValid", MAPB'(deactValid), '0);

    step(1, 0, 8'h40, 8'hFF, 0, 0, 0, 0, 64, 1, "R2 word1");
    chk("R2 bit32", MAPB'(activeMap[32]), MAPB'(1'b1));
    chk("R9 ns view", MAPB'(readPrio), MAPB'(8'h80));
    step(1, 2, 8'h3E, 8'hF0, 0, 0, 0, 0, 64, 0, "R2 masked");
    chk("R2 bit24", MAPB'(activeMap[2*MAPB + 24]), MAPB'(1'b1));
    chk("R8 prio30", MAPB'(runPrio), MAPB'(8'h30));
    step(1, 3, 8'h10, 8'hFF, 0, 0, 0, 0, 64, 0, "R2 grp3");
    step(0, 0, 0, 0, 1, 24'd5, 0, 0, 64, 0, "R6 wrong grp");
    step(0, 0, 0, 0, 1, 24'd70, 2, 0, 64, 0, "R5 big id");
    step(0, 0, 0, 0, 1, 24'd1023, 2, 0, 1020, 0, "R5 special id");
    step(0, 0, 0, 0, 1, 24'd9, 2, 1, 64, 0, "R7 split");
    step(1, 1, 8'h40, 8'hFF, 0, 0, 0, 0, 64, 0, "R4 tie set");
    step(0, 0, 0, 0, 1, 24'd3, 1, 0, 64, 0, "R4 tie g1 loses");
    step(0, 0, 0, 0, 1, 24'd12, 0, 0, 64, 1, "R7 unsplit");
    step(1, 0, 8'hFE, 8'hFF, 0, 0, 0, 0, 64, 0, "R2 idx127");
    step(0, 0, 0, 0, 1, 24'd3, 1, 0, 64, 1, "R3 R9 drop g1");
    chk("R9 secure half", MAPB'(readPrio), '0);
    step(1, 2, 8'h02, 8'hFF, 1, 24'd4, 2, 0, 64, 0, "R10 same cycle");
    step(0, 0, 0, 0, 1, 24'd6, 0, 0, 64, 1, "R3 last");
    step(0, 0, 0, 0, 1, 24'd6, 0, 0, 64, 1, "R4 empty");
    chk("R9 idle ns", MAPB'(readPrio), '0);

    for (int n = 0; n < 3000; n++) begin
      ag = $urandom_range(0, 3);
      eg = ($urandom_range(0, 9) < 7) ? winner() : $urandom_range(0, 3);
      step($urandom_range(0, 1), 2'(ag), 8'($urandom), masks[$urandom_range(0, 4)],
           $urandom_range(0, 1), ($urandom_range(0, 9) == 0) ? 24'(1020 + $urandom_range(0, 3)) : 24'($urandom_range(0, 80)),
           2'(eg), $urandom_range(0, 1), ($urandom_range(0, 1) != 0) ? 25'd64 : 25'd1020,
           $urandom_range(0, 1), "R2 R3 R4 R10 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule